// File: doc/BRIEF.md
# Accumulator Machine Shared-Bus Register Datapath

This block holds the working registers of a small accumulator machine and the single 16-bit bus that moves values between them. Two 12-bit registers keep the memory address and the program counter. Four 16-bit registers keep memory data, the accumulator, the fetched instruction and a scratch value. Two 8-bit registers keep the incoming and outgoing characters. The block makes no decisions of its own. An external controller raises one-hot source requests and per-register strobes, and the block carries them out on the next rising clock edge.

An encoder turns the source requests into a 3-bit bus select code. The selected register, or the memory read data, drives the bus. Every destination whose load strobe is high captures that bus value on the same edge. The address register addresses a 4096-word, 16-bit memory outside the block. A write request stores the current bus value at that address. The memory read port returns data within the same cycle.

Top module: `sbus_datapath`

## Requirements
- R1: Request bit k-1 of `src_req` asks for source code k (bit0 AR, bit1 PC, bit2 DR, bit3 AC, bit4 IR, bit5 TR, bit6 memory). `bus_sel` equals the highest requested code, and equals 0 when no bit is set.
- R2: When `bus_sel` is 0, the bus reads as all zeros.
- R3: Codes 1 to 6 place AR, PC, DR, AC, IR and TR on the bus. The 12-bit AR and PC are zero-extended in bits 15:12.
- R4: Code 7 places `mem_rdata` on the bus. `mem_rd` is high in exactly those cycles.
- R5: `mem_addr` always equals AR. `mem_wdata` always equals the bus, and `mem_wr` follows `wr_req` in the same cycle.
- R6: `ld_en` bits (0 AR, 1 PC, 2 DR, 3 AC, 4 TR, 5 IR, 6 OUTR) load the bus value at the next rising edge. Any number of them may load one bus value at once, and AR and PC keep bits 11:0.
- R7: OUTR loads only bus bits 7:0.
- R8: `inc_en` bits (0 AR, 1 PC, 2 DR, 3 AC, 4 TR) add one at the edge, wrapping at 12 bits for AR and PC and at 16 bits for the others.
- R9: Within one register, the `clr_en` bit (same indexing as `inc_en`) wins over load, and load wins over increment.
- R10: INPR loads `in_char` at the edge when `in_ld` is high. It is not a bus source.
- R11: While reset is asserted, every register reads zero. Registers leave reset two rising edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 7 | One-hot bus source requests |
| ld_en | input | 7 | Per-destination load strobes |
| inc_en | input | 5 | Increment strobes for AR, PC, DR, AC, TR |
| clr_en | input | 5 | Clear strobes for AR, PC, DR, AC, TR |
| wr_req | input | 1 | Memory write request |
| in_ld | input | 1 | Load strobe for the input character register |
| in_char | input | 8 | Character from the input device |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 12 | Memory address (AR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (bus) |
| bus_sel | output | 3 | Encoded bus source |
| bus | output | 16 | Shared bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| outr_q | output | 8 | Output character register |
| inpr_q | output | 8 | Input character register |

## Verification
The most delicate overlap is a register that drives the bus while it also receives a strobe on the same edge. Examples are DR on the bus while DR increments and AC loads, or memory selected while AR is being reloaded. Directed cycles set up these overlaps, together with strobe combinations that hit the clear-over-load-over-increment order. A long pseudo-random sequence mixes them freely. Each cycle is judged against a behavioural model that uses the pre-edge bus value for every destination, so a register must pass its old content and take its new one in the same cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 16;
  localparam int CHAR_W  = 8;
  localparam int SEL_W   = 3;
  localparam int N_SRC   = 7;
  localparam int N_DEST  = 7;
  localparam int N_CTL   = 5;
  localparam int EXT_W   = DATA_W - ADDR_W;

  // destination / strobe indices
  localparam int IX_AR   = 0;
  localparam int IX_PC   = 1;
  localparam int IX_DR   = 2;
  localparam int IX_AC   = 3;
  localparam int IX_TR   = 4;
  localparam int IX_IR   = 5;
  localparam int IX_OUTR = 6;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } src_e;
endpackage

// File: rtl/sbus_encoder.sv
module sbus_encoder
  import sbus_pkg::*;
#(
  parameter int NREQ = N_SRC,
  parameter int CW   = SEL_W
) (
  input  logic [NREQ-1:0] req,
  output logic [CW-1:0]   code
);
  // highest requested source wins
  always_comb begin
    code = '0;
    for (int k = 0; k < NREQ; k++) begin
      if (req[k]) code = CW'(k + 1);
    end
  end
endmodule

// File: rtl/sbus_mux.sv
module sbus_mux
  import sbus_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] ar,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] dr,
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] ir,
  input  logic [DATA_W-1:0] tr,
  input  logic [DATA_W-1:0] mem,
  output logic [DATA_W-1:0] bus
);
  always_comb begin
    unique case (src_e'(sel))
      SRC_AR:  bus = {{EXT_W{1'b0}}, ar};
      SRC_PC:  bus = {{EXT_W{1'b0}}, pc};
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/sbus_reg.sv
module sbus_reg #(
  parameter int W       = 16,
  parameter bit HAS_CTL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         clr_g, inc_g, en;
  logic [W-1:0] nxt;

  // strobes that a load-only register does not honour are gated off
  assign clr_g = clr & HAS_CTL;
  assign inc_g = inc & HAS_CTL;
  assign en    = clr_g | ld | inc_g;

  always_comb begin
    if (clr_g)      nxt = '0;
    else if (ld)    nxt = d;
    else if (inc_g) nxt = q + ONE;
    else            nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (en)  q <= nxt;
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req,
  input  logic [N_DEST-1:0] ld_en,
  input  logic [N_CTL-1:0]  inc_en,
  input  logic [N_CTL-1:0]  clr_en,
  input  logic              wr_req,
  input  logic              in_ld,
  input  logic [CHAR_W-1:0] in_char,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] dr_q,
  output logic [DATA_W-1:0] ac_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] tr_q,
  output logic [CHAR_W-1:0] outr_q,
  output logic [CHAR_W-1:0] inpr_q
);
  // reset: asserted asynchronously, released after two edges
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  sbus_encoder u_enc (.req(src_req), .code(bus_sel));

  sbus_mux u_mux (
    .sel(bus_sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
    .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .bus(bus)
  );

  assign mem_addr  = ar_q;
  assign mem_rd    = (bus_sel == SRC_MEM);
  assign mem_wr    = wr_req;
  assign mem_wdata = bus;

  sbus_reg #(.W(ADDR_W)) u_ar (
    .clk(clk), .rst_n(rst_q), .ld(ld_en[IX_AR]), .inc(inc_en[IX_AR]),
    .clr(clr_en[IX_AR]), .d(bus[ADDR_W-1:0]), .q(ar_q));
  sbus_reg #(.W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_q), .ld(ld_en[IX_PC]), .inc(inc_en[IX_PC]),
    .clr(clr_en[IX_PC]), .d(bus[ADDR_W-1:0]), .q(pc_q));
  sbus_reg #(.W(DATA_W)) u_dr (
    .clk(clk), .rst_n(rst_q), .ld(ld_en[IX_DR]), .inc(inc_en[IX_DR]),
    .clr(clr_en[IX_DR]), .d(bus), .q(dr_q));
  sbus_reg #(.W(DATA_W)) u_ac (
    .clk(clk), .rst_n(rst_q), .ld(ld_en[IX_AC]), .inc(inc_en[IX_AC]),
    .clr(clr_en[IX_AC]), .d(bus), .q(ac_q));
  sbus_reg #(.W(DATA_W)) u_tr (
    .clk(clk), .rst_n(rst_q), .ld(ld_en[IX_TR]), .inc(inc_en[IX_TR]),
    .clr(clr_en[IX_TR]), .d(bus), .q(tr_q));
  sbus_reg #(.W(DATA_W), .HAS_CTL(1'b0)) u_ir (
    .clk(clk), .rst_n(rst_q), .ld(ld_en[IX_IR]), .inc(1'b0),
    .clr(1'b0), .d(bus), .q(ir_q));
  sbus_reg #(.W(CHAR_W), .HAS_CTL(1'b0)) u_outr (
    .clk(clk), .rst_n(rst_q), .ld(ld_en[IX_OUTR]), .inc(1'b0),
    .clr(1'b0), .d(bus[CHAR_W-1:0]), .q(outr_q));
  sbus_reg #(.W(CHAR_W), .HAS_CTL(1'b0)) u_inpr (
    .clk(clk), .rst_n(rst_q), .ld(in_ld), .inc(1'b0),
    .clr(1'b0), .d(in_char), .q(inpr_q));
endmodule

// File: rtl/sbus_checker.sv
module sbus_checker
  import sbus_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic [N_SRC-1:0]  src_req,
  input logic [N_DEST-1:0] ld_en,
  input logic [N_CTL-1:0]  inc_en,
  input logic [N_CTL-1:0]  clr_en,
  input logic [SEL_W-1:0]  bus_sel,
  input logic [DATA_W-1:0] bus,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] ar_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ac_q,
  input logic [CHAR_W-1:0] outr_q
);
  p_no_req_r1: assert property (@(posedge clk) disable iff (!rst_q)
    src_req == '0 |-> bus_sel == 3'd0);
  p_mem_top_r1: assert property (@(posedge clk) disable iff (!rst_q)
    src_req[6] |-> bus_sel == 3'd7);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_q)
    bus_sel == 3'd0 |-> bus == '0);
  p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel == 3'd1 || bus_sel == 3'd2) |-> bus[DATA_W-1:ADDR_W] == '0);
  p_mem_rd_r4: assert property (@(posedge clk) disable iff (!rst_q)
    mem_rd |-> (bus == mem_rdata && bus_sel == 3'd7));
  p_addr_r5: assert property (@(posedge clk) disable iff (!rst_q)
    mem_addr == ar_q);
  p_ac_load_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (ld_en[IX_AC] && !clr_en[IX_AC]) |=> ac_q == $past(bus));
  p_outr_low_r7: assert property (@(posedge clk) disable iff (!rst_q)
    ld_en[IX_OUTR] |=> outr_q == $past(bus[CHAR_W-1:0]));
  p_pc_inc_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (inc_en[IX_PC] && !ld_en[IX_PC] && !clr_en[IX_PC]) |=> pc_q == $past(pc_q) + 12'd1);
  p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_q)
    clr_en[IX_AR] |=> ar_q == '0);
endmodule

bind sbus_datapath sbus_checker u_sbus_checker (
  .clk(clk), .rst_q(rst_q), .src_req(src_req), .ld_en(ld_en),
  .inc_en(inc_en), .clr_en(clr_en), .bus_sel(bus_sel), .bus(bus),
  .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .ar_q(ar_q), .pc_q(pc_q), .ac_q(ac_q), .outr_q(outr_q)
);

// File: tb/sbus_datapath_bench.sv
`timescale 1ns/1ps
module sbus_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  src_req;
  logic [6:0]  ld_en;
  logic [4:0]  inc_en, clr_en;
  logic        wr_req, in_ld;
  logic [7:0]  in_char;
  logic [15:0] mem_rdata, mem_wdata, bus, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] mem_addr, ar_q, pc_q;
  logic        mem_rd, mem_wr;
  logic [2:0]  bus_sel;
  logic [7:0]  outr_q, inpr_q;

  always #2.5 clk = ~clk;

  sbus_datapath u_sbus_datapath (.*);

  // environment memory
  logic [15:0] mem [4096];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  int n_cmp = 0, n_bad = 0;
  int m_ar, m_pc, m_dr, m_ac, m_ir, m_tr, m_outr, m_inpr;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int upd(int v, int mask, bit l, bit i, bit c, int b);
    if (c) return 0;
    if (l) return b & mask;
    if (i) return (v + 1) & mask;
    return v;
  endfunction

  task automatic chk_regs();
    chk("R6 R8 R9 ar", int'(ar_q), m_ar);
    chk("R6 R8 R9 pc", int'(pc_q), m_pc);
    chk("R6 R8 R9 dr", int'(dr_q), m_dr);
    chk("R6 R8 R9 ac", int'(ac_q), m_ac);
    chk("R6 R8 R9 tr", int'(tr_q), m_tr);
    chk("R6 ir",       int'(ir_q), m_ir);
    chk("R7 outr",     int'(outr_q), m_outr);
    chk("R10 inpr",    int'(inpr_q), m_inpr);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [6:0] rq, input logic [6:0] ld,
                      input logic [4:0] inc, input logic [4:0] clr,
                      input logic wr, input logic ild, input logic [7:0] ich);
    int esel, ebus;
    src_req = rq; ld_en = ld; inc_en = inc; clr_en = clr;
    wr_req = wr; in_ld = ild; in_char = ich;
    #1;
    esel = 0;
    for (int k = 1; k <= 7; k++) if (rq[k-1]) esel = k;
    case (esel)
      1: ebus = m_ar;  2: ebus = m_pc;  3: ebus = m_dr;
      4: ebus = m_ac;  5: ebus = m_ir;  6: ebus = m_tr;
      7: ebus = int'(mem[m_ar]);
      default: ebus = 0;
    endcase
    chk("R1 bus_sel", int'(bus_sel), esel);
    chk(esel == 0 ? "R2 bus" : (esel == 7 ? "R4 bus" : "R3 bus"), int'(bus), ebus);
    chk("R4 mem_rd", int'(mem_rd), int'(esel == 7));
    chk("R5 mem_addr", int'(mem_addr), m_ar);
    chk("R5 mem_wdata", int'(mem_wdata), ebus);
    chk("R5 mem_wr", int'(mem_wr), int'(wr));
    @(posedge clk);
    m_ar   = upd(m_ar, 'hFFF,  ld[0], inc[0], clr[0], ebus);
    m_pc   = upd(m_pc, 'hFFF,  ld[1], inc[1], clr[1], ebus);
    m_dr   = upd(m_dr, 'hFFFF, ld[2], inc[2], clr[2], ebus);
    m_ac   = upd(m_ac, 'hFFFF, ld[3], inc[3], clr[3], ebus);
    m_tr   = upd(m_tr, 'hFFFF, ld[4], inc[4], clr[4], ebus);
    m_ir   = upd(m_ir, 'hFFFF, ld[5], 1'b0, 1'b0, ebus);
    m_outr = upd(m_outr, 'hFF, ld[6], 1'b0, 1'b0, ebus);
    m_inpr = upd(m_inpr, 'hFF, ild, 1'b0, 1'b0, int'(ich));
    @(negedge clk);
    chk_regs();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lf;
    for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 40503) ^ 16'h5A5A;
    mem[0] = 16'hFFFF;
    mem[1] = 16'h8ABC;
    src_req = '0; ld_en = '0; inc_en = '0; clr_en = '0;
    wr_req = 0; in_ld = 0; in_char = '0;
    m_ar = 0; m_pc = 0; m_dr = 0; m_ac = 0; m_ir = 0; m_tr = 0; m_outr = 0; m_inpr = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R11: reset state, strobes held high must have no effect
    ld_en = '1; inc_en = '1; src_req = 7'h40;
    @(negedge clk);
    chk("R11 ar", int'(ar_q), 0); chk("R11 ac", int'(ac_q), 0);
    chk("R11 ir", int'(ir_q), 0); chk("R11 outr", int'(outr_q), 0);
    ld_en = '0; inc_en = '0; src_req = '0;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_regs();
    // R6 R7: memory word FFFF into every destination at once
    step(7'h40, 7'h7F, 5'h00, 5'h00, 0, 1, 8'hC3);
    // R3 R8: PC on bus is zero-extended, then wraps FFF -> 000
    step(7'h02, 7'h04, 5'h02, 5'h00, 0, 0, 8'h00);
    // R8: AC FFFF -> 0000, AR FFF -> 000
    step(7'h00, 7'h00, 5'h09, 5'h00, 0, 0, 8'h00);
    // R9: clear beats load and increment; load beats increment
    step(7'h20, 7'h1F, 5'h1F, 5'h05, 0, 0, 8'h00);
    // every select code, each loading the accumulator and outr
    for (int k = 0; k < 7; k++) step(7'(1 << k), 7'h48, 5'h00, 5'h00, 0, 0, 8'h00);
    // R1: several requests, highest wins
    step(7'h0B, 7'h10, 5'h00, 5'h00, 0, 0, 8'h00);
    step(7'h7F, 7'h20, 5'h00, 5'h00, 0, 0, 8'h00);
    // DR drives the bus while it increments and AC loads
    step(7'h04, 7'h08, 5'h04, 5'h00, 0, 0, 8'h00);
    // memory selected while AR reloads from it
    step(7'h40, 7'h01, 5'h00, 5'h00, 0, 0, 8'h00);
    // R5: write AC to memory, then read it back
    step(7'h08, 7'h00, 5'h00, 5'h00, 1, 0, 8'h00);
    step(7'h40, 7'h04, 5'h00, 5'h00, 0, 0, 8'h00);
    // pseudo-random mix
    lf = 32'h1D2C3B4A;
    for (int n = 0; n < 2000; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
      step(7'(1 << (lf & 7)) & 7'h7F, 7'(lf >> 3), 5'(lf >> 10),
           ((lf >> 15) & 7) == 0 ? 5'(lf >> 18) : 5'h00,
           ((lf >> 23) & 3) == 0, lf[25], 8'(lf >> 24));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule